// File: doc/BRIEF.md
# Three-Edge Chip-Select Converter Sequencer

This block is the digital control core of a successive-approximation converter whose result leaves on a 14-bit parallel bus. A host drives an active-low chip-select and a read/convert level. Both pass through a two-flop synchronizer, and falling edges of chip-select are detected in the internal clock domain. Each falling edge has its own meaning, qualified by the read/convert level seen at that edge. The first edge wakes the reference and starts tracking. The second edge freezes the sample, starts the conversion and records the power mode to apply once the result is ready. The third edge puts the result on the bus.

The conversion engine decides one bit per `BIT_CYC` internal clock cycles, MSB first. It drives a trial word to an external comparator and reads back one decision bit. When the result is ready, the end-of-conversion flag goes low. The reference enable then either stays on (standby) or drops (shutdown), as chosen at the second edge. The bus is modelled as a data register with a separate three-state enable. There is no data stream here, so all pins are plain control and status levels with no valid/ready handshake.

Top module: `tes_adc_seq`

## Requirements
- R1: While `rst` is high and after it falls, `eoc_n_o`=1, `bus_oe_o`=0, `ref_en_o`=0, `track_o`=0 and `hold_o`=0.
- R2: In idle, a chip-select falling edge with read/convert low sets `track_o`=1 and `ref_en_o`=1. Tracking continues after chip-select rises again.
- R3: In idle, a chip-select falling edge with read/convert high is ignored: `track_o` and `ref_en_o` stay 0.
- R4: While tracking, the next chip-select falling edge sets `hold_o`=1 and clears `track_o`. Chip-select edges during the conversion do not disturb it or its result.
- R5: The result is resolved MSB first: bit k of `trial_o` is set while bit k is under test, and it stays set when `cmp_i`=1. A comparator that returns 1 exactly when trial <= V yields a result equal to V. `eoc_n_o` falls within NB*BIT_CYC+12 cycles of the converting edge reaching `cs_n_i`.
- R6: When `eoc_n_o` falls, `ref_en_o` is 0 if read/convert was high at the converting edge (shutdown), and 1 if it was low (standby).
- R7: After the result is ready, a chip-select falling edge with read/convert high sets `bus_oe_o`=1 within 10 cycles, with `bus_data_o` equal to the result. The same edge with read/convert low is ignored and leaves `bus_oe_o`=0.
- R8: `bus_oe_o` is 0 whenever `track_o` or `hold_o` is 1.
- R9: Chip-select rising after the read returns `bus_oe_o` to 0 and `eoc_n_o` to 1, and the block waits in idle.
- R10: A reset pulse while chip-select is high ends tracking and turns off the reference. The next falling edge with read/convert low starts tracking again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst | input | 1 | Active-high reset to idle |
| cs_n_i | input | 1 | Asynchronous active-low chip-select |
| rd_conv_i | input | 1 | Asynchronous read/convert qualifier |
| cmp_i | input | 1 | Comparator decision: 1 keeps the bit under test |
| trial_o | output | NB | Trial code presented to the comparator |
| track_o | output | 1 | Sample is tracking the input |
| hold_o | output | 1 | Sample held, conversion running |
| eoc_n_o | output | 1 | End of conversion, low when the result is ready |
| ref_en_o | output | 1 | Reference and buffer power enable |
| bus_oe_o | output | 1 | Three-state enable for the data bus |
| bus_data_o | output | NB | Conversion result register |

## Verification
The bench goes after the edge-qualification corners. A falling edge with read/convert high in idle must not wake the reference; a design that ignored the qualifier would set `ref_en_o`. A read attempt with read/convert low after completion must not enable the bus; a sloppy decoder would drive early. Extra chip-select edges during conversion must not restart or corrupt the result; a design that restarts would return a wrong code or finish late. The extreme codes 0, 1, 16382 and 16383, and the mid-scale codes on both sides of 8192, catch SAR bit-order and last-bit errors. Both power modes are checked at the end of conversion, which catches an inverted or unlatched mode bit.

// File: rtl/tes_pkg.sv
package tes_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_DONE,
    ST_READ
  } seq_state_e;
endpackage

// File: rtl/tes_sync.sv
module tes_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst) sh_q <= {STAGES{RST_VAL[g]}};
      else     sh_q <= {sh_q[STAGES-2:0], d[g]};
    end
    assign q[g] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/tes_sar.sv
module tes_sar #(
  parameter int NB      = 14,
  parameter int BIT_CYC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cmp,
  output logic [NB-1:0] trial,
  output logic [NB-1:0] result,
  output logic          done
);
  localparam int DW = $clog2(BIT_CYC + 1);

  logic          busy_q;
  logic [DW-1:0] div_q;
  logic [NB-1:0] acc_q, mask_q;

  assign trial = acc_q | mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      div_q  <= '0;
      acc_q  <= '0;
      mask_q <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        div_q  <= '0;
        acc_q  <= '0;
        mask_q <= {1'b1, {(NB-1){1'b0}}};
      end else if (busy_q) begin
        if (div_q == DW'(BIT_CYC - 1)) begin
          div_q <= '0;
          if (cmp) acc_q <= acc_q | mask_q;
          mask_q <= mask_q >> 1;
          if (mask_q[0]) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
            result <= cmp ? (acc_q | mask_q) : acc_q;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tes_ctrl.sv
module tes_ctrl
  import tes_pkg::*;
#(
  parameter int OUT_DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_conv,
  input  logic sar_done,
  output logic sar_start,
  output logic track,
  output logic hold,
  output logic eoc_n,
  output logic ref_en,
  output logic bus_oe
);
  localparam int CW = $clog2(OUT_DLY + 1);

  seq_state_e    state_q;
  logic          cs_prev_q;
  logic          mode_sd_q;
  logic [CW-1:0] dly_q;
  logic          cs_fall, cs_rise;

  assign cs_fall   = cs_prev_q & ~cs_n;
  assign cs_rise   = ~cs_prev_q & cs_n;
  assign sar_start = (state_q == ST_ACQ) && cs_fall;
  assign track     = (state_q == ST_ACQ);
  assign hold      = (state_q == ST_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cs_prev_q <= 1'b1;
      mode_sd_q <= 1'b0;
      dly_q     <= '0;
      eoc_n     <= 1'b1;
      ref_en    <= 1'b0;
      bus_oe    <= 1'b0;
    end else begin
      cs_prev_q <= cs_n;
      unique case (state_q)
        ST_IDLE: if (cs_fall && !rd_conv) begin
          state_q <= ST_ACQ;
          ref_en  <= 1'b1;
        end
        ST_ACQ: if (cs_fall) begin
          state_q   <= ST_CONV;
          mode_sd_q <= rd_conv;
        end
        ST_CONV: if (sar_done) begin
          state_q <= ST_DONE;
          eoc_n   <= 1'b0;
          if (mode_sd_q) ref_en <= 1'b0;
        end
        ST_DONE: if (cs_fall && rd_conv) begin
          state_q <= ST_READ;
          dly_q   <= '0;
        end
        ST_READ: begin
          if (cs_rise) begin
            state_q <= ST_IDLE;
            bus_oe  <= 1'b0;
            eoc_n   <= 1'b1;
          end else if (dly_q == CW'(OUT_DLY)) begin
            bus_oe <= 1'b1;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tes_adc_seq.sv
module tes_adc_seq #(
  parameter int NB      = 14,
  parameter int BIT_CYC = 8,
  parameter int OUT_DLY = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_i,
  input  logic          rd_conv_i,
  input  logic          cmp_i,
  output logic [NB-1:0] trial_o,
  output logic          track_o,
  output logic          hold_o,
  output logic          eoc_n_o,
  output logic          ref_en_o,
  output logic          bus_oe_o,
  output logic [NB-1:0] bus_data_o
);
  logic [1:0] sync_q;
  logic       sar_start, sar_done;

  tes_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rd_conv_i, cs_n_i}),
    .q   (sync_q)
  );

  tes_ctrl #(.OUT_DLY(OUT_DLY)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (sync_q[0]),
    .rd_conv   (sync_q[1]),
    .sar_done  (sar_done),
    .sar_start (sar_start),
    .track     (track_o),
    .hold      (hold_o),
    .eoc_n     (eoc_n_o),
    .ref_en    (ref_en_o),
    .bus_oe    (bus_oe_o)
  );

  tes_sar #(.NB(NB), .BIT_CYC(BIT_CYC)) u_sar (
    .clk    (clk),
    .rst    (rst),
    .start  (sar_start),
    .cmp    (cmp_i),
    .trial  (trial_o),
    .result (bus_data_o),
    .done   (sar_done)
  );
endmodule

// File: rtl/tes_adc_seq_chk.sv
module tes_adc_seq_chk #(
  parameter int NB      = 14,
  parameter int BIT_CYC = 8
) (
  input logic clk,
  input logic rst,
  input logic track_o,
  input logic hold_o,
  input logic eoc_n_o,
  input logic ref_en_o,
  input logic bus_oe_o
);
  localparam int LIMIT = NB * BIT_CYC + 4;
  localparam int CW    = $clog2(LIMIT + 2) + 1;

  logic [CW-1:0] hold_cnt_q;
  always_ff @(posedge clk) begin
    if (rst || !hold_o) hold_cnt_q <= '0;
    else if (hold_cnt_q != '1) hold_cnt_q <= hold_cnt_q + 1'b1;
  end

  // R8
  bus_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (track_o || hold_o) |-> !bus_oe_o);

  // R4
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({track_o, hold_o}));

  // R2
  acq_ref_chk: assert property (@(posedge clk) disable iff (rst)
    track_o |-> ref_en_o);

  // R7
  oe_after_eoc_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o |-> !eoc_n_o);

  // R5
  conv_time_chk: assert property (@(posedge clk) disable iff (rst)
    hold_cnt_q <= CW'(LIMIT));

  // R5
  hold_end_eoc_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_o) |-> !eoc_n_o);

  // R9
  eoc_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc_n_o) |-> !bus_oe_o);
endmodule

bind tes_adc_seq tes_adc_seq_chk #(.NB(NB), .BIT_CYC(BIT_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .track_o  (track_o),
  .hold_o   (hold_o),
  .eoc_n_o  (eoc_n_o),
  .ref_en_o (ref_en_o),
  .bus_oe_o (bus_oe_o)
);

// File: tb/sim_tes_adc_seq.sv
module sim_tes_adc_seq;
  localparam int NB         = 14;
  localparam int BIT_CYC    = 8;
  localparam int OUT_DLY    = 3;
  localparam int CONV_LIMIT = NB * BIT_CYC + 12;

  // {shutdown_mode, input code}
  localparam logic [14:0] VEC [8] = '{
    15'h0000, 15'h7FFF, 15'h2000, 15'h5FFF,
    15'h2AAA, 15'h5555, 15'h0001, 15'h7FFE
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          rd_conv = 1'b1;
  logic          cmp;
  logic [NB-1:0] trial, bus_data;
  logic          track, hold, eoc_n, ref_en, bus_oe;
  logic [NB-1:0] vin = '0;
  int            errs = 0;
  int            checks = 0;

  always #5 clk = ~clk;

  assign cmp = (trial <= vin);

  tes_adc_seq #(.NB(NB), .BIT_CYC(BIT_CYC), .OUT_DLY(OUT_DLY)) u0 (
    .clk (clk), .rst (rst), .cs_n_i (cs_n), .rd_conv_i (rd_conv),
    .cmp_i (cmp), .trial_o (trial), .track_o (track), .hold_o (hold),
    .eoc_n_o (eoc_n), .ref_en_o (ref_en), .bus_oe_o (bus_oe),
    .bus_data_o (bus_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_fall(input logic rc);
    rd_conv = rc;
    settle(2);
    cs_n = 1'b0;
    settle(10);
  endtask

  task automatic cs_rise();
    cs_n = 1'b1;
    settle(10);
  endtask

  // Converting edge; optional extra chip-select pulse mid-conversion.
  task automatic convert(input logic mode, input bit glitch, output int n);
    rd_conv = mode;
    settle(2);
    cs_n = 1'b0;
    n = 0;
    while (eoc_n && n < 1000) begin
      @(negedge clk);
      n++;
      if (n == 10) chk("R4 hold after converting edge", int'(hold), 1);
      if (n == 10) chk("R4 track cleared", int'(track), 0);
      if (n == 20) cs_n = 1'b1;
      if (glitch && n == 40) cs_n = 1'b0;
      if (glitch && n == 55) begin
        chk("R4 hold kept through extra edge", int'(hold), 1);
        cs_n = 1'b1;
      end
    end
    if (n < 21) begin
      cs_n = 1'b1;
      settle(10);
    end
  endtask

  task automatic full_cycle(input logic [NB-1:0] code, input logic mode, input bit glitch);
    int n;
    vin = code;
    cs_fall(1'b0);
    chk("R2 track on wake edge", int'(track), 1);
    chk("R2 reference on", int'(ref_en), 1);
    chk("R8 bus off during tracking", int'(bus_oe), 0);
    cs_rise();
    chk("R2 tracking holds after rise", int'(track), 1);
    convert(mode, glitch, n);
    chk("R5 conversion within limit", int'(n <= CONV_LIMIT), 1);
    chk("R6 reference after conversion", int'(ref_en), int'(!mode));
    chk("R8 bus off at end of conversion", int'(bus_oe), 0);
    cs_fall(1'b1);
    chk("R7 bus enabled on read", int'(bus_oe), 1);
    chk("R5 result code", int'(bus_data), int'(code));
    cs_rise();
    chk("R9 bus off after rise", int'(bus_oe), 0);
    chk("R9 eoc high after rise", int'(eoc_n), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    settle(5);
    chk("R1 eoc during reset", int'(eoc_n), 1);
    rst = 1'b0;
    settle(5);
    chk("R1 eoc after reset", int'(eoc_n), 1);
    chk("R1 bus off", int'(bus_oe), 0);
    chk("R1 reference off", int'(ref_en), 0);
    chk("R1 not tracking", int'(track), 0);
    chk("R1 not holding", int'(hold), 0);

    // R3: wake edge with read/convert high is ignored
    cs_fall(1'b1);
    chk("R3 no tracking", int'(track), 0);
    chk("R3 reference stays off", int'(ref_en), 0);
    cs_rise();
    chk("R3 still idle", int'(track), 0);

    for (int i = 0; i < 8; i++) begin
      full_cycle(VEC[i][13:0], VEC[i][14], 1'b0);
    end

    // R4: extra chip-select pulse mid-conversion is ignored
    full_cycle(14'h3A5C, 1'b0, 1'b1);

    // R7: read attempt with read/convert low is ignored
    begin
      int n;
      vin = 14'h1234;
      cs_fall(1'b0);
      cs_rise();
      convert(1'b1, 1'b0, n);
      cs_fall(1'b0);
      chk("R7 low-qualified read ignored", int'(bus_oe), 0);
      chk("R7 no new tracking", int'(track), 0);
      cs_rise();
      cs_fall(1'b1);
      chk("R7 qualified read drives bus", int'(bus_oe), 1);
      chk("R7 read data", int'(bus_data), 14'h1234);
      cs_rise();
    end

    // R10: reset during tracking
    cs_fall(1'b0);
    cs_rise();
    chk("R10 tracking before reset", int'(track), 1);
    rst = 1'b1;
    settle(3);
    rst = 1'b0;
    settle(3);
    chk("R10 tracking cleared", int'(track), 0);
    chk("R10 reference off", int'(ref_en), 0);
    cs_fall(1'b0);
    chk("R10 next edge tracks", int'(track), 1);
    cs_rise();

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule